// File: doc/BRIEF.md
# Dual-Enable Word Store with Bank-Select Address Multiplexer

This block is a clocked single-port word memory. It is selected by a pair of chip enables of opposite polarity, and it has separate write-enable and output-enable controls. The most significant address bit does not come from a fixed pin. A one-bit multiplexer picks it, steered by a mode input: either the ordinary top address line or a separate space-select line. This lets a processor that flags its operand space on its own pin share one array between two operand spaces and repartition it on the fly, with no extra glue logic.

The read bus is split into a registered data output and a registered drive flag, which stand in for a three-state pad. Every control is sampled on the rising clock edge. A write commits on the edge where the write condition is seen. Read data and the drive flag appear one cycle after a valid read condition is sampled.

A small state machine tracks the access. Its states are:
- STANDBY: not selected.
- QUIET: selected with the output disabled.
- READ: driving the output.
- WRITE: a write entered from a selected state.
- LOCK: the chip was selected while write enable was already low.

Its transitions are:
- Deselect: any state goes to STANDBY.
- Select-with-write: STANDBY goes to LOCK.
- Select: STANDBY goes to READ or QUIET.
- Write-entry: QUIET, READ or WRITE goes to WRITE.
- Read-entry and output-off: QUIET, READ or WRITE goes to READ or QUIET.
- Lock-hold: LOCK stays in LOCK while selected.

The word count is 2^(LOW_AW+1). Setting LOW_AW to 12 gives the full 8,192 × 24 organisation. The default is kept smaller.

Top module: `dual_en_sram`

## Requirements
- R1: The top address bit equals `space_sel` when `mux_ctl` is 1 and `addr_top` when `mux_ctl` is 0. The full word address is {top bit, `addr_lo`}.
- R2: The block is selected only when `ce_lo_n` is 0 and `ce_hi` is 1. In any other cycle, no write happens and `rdata_drive` is 0 after the next edge.
- R3: A selected cycle with `we_n`=1 and `oe_n`=0, outside LOCK, makes `rdata_drive` 1 and `rdata` equal to the stored word one cycle later.
- R4: A selected cycle with `we_n`=1 and `oe_n`=1 writes nothing and leaves `rdata_drive` 0 one cycle later.
- R5: A selected cycle with `we_n`=0 stores `wdata` at the muxed address, whatever the value of `oe_n`. After that edge, `rdata_drive` is 0.
- R6: If `we_n` is 0 in the first selected cycle, `rdata_drive` stays 0 until the block is deselected, even if a read condition follows.
- R7: Whenever `rdata_drive` is 0, `rdata` reads as all zeros.
- R8: After reset, `rdata_drive` and `rdata` are 0 and the machine is in STANDBY.
- R9: Two addresses with the same `addr_lo` but different top bits hold independent words.
- R10: A word written in one cycle is returned by a read in the next cycle, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_lo_n | input | 1 | Chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_lo | input | LOW_AW | Low address bits |
| addr_top | input | 1 | Ordinary top address candidate |
| space_sel | input | 1 | Operand-space top address candidate |
| mux_ctl | input | 1 | Selects the top bit source (1 = space_sel) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero when undriven |
| rdata_drive | output | 1 | Registered output-drive flag |

## Verification
The two functions that can share a cycle are the end of an output drive and the commit of a write. When `we_n` falls while the block is in READ, the same edge must store the new word and drop `rdata_drive`. The bench provokes this with a back-to-back read, write, read at one address. It judges the result by seeing the drive flag low after the write edge and the new word on the very next read.

// File: rtl/dual_en_sram_pkg.sv
package dual_en_sram_pkg;
    typedef enum logic [2:0] {
        ST_STANDBY = 3'd0,
        ST_QUIET   = 3'd1,
        ST_READ    = 3'd2,
        ST_WRITE   = 3'd3,
        ST_LOCK    = 3'd4
    } acc_state_t;
endpackage

// File: rtl/dsr_select_decode.sv
module dsr_select_decode (
    input  logic ce_lo_n,
    input  logic ce_hi,
    input  logic we_n,
    input  logic oe_n,
    output logic sel,
    output logic wr,
    output logic rd_req
);
    always_comb begin
        sel    = !ce_lo_n && ce_hi;
        wr     = sel && !we_n;
        rd_req = sel && we_n && !oe_n;
    end
endmodule

// File: rtl/dsr_addr_mux.sv
module dsr_addr_mux #(
    parameter int LOW_AW = 10,
    localparam int FULL_AW = LOW_AW + 1
) (
    input  logic [LOW_AW-1:0]  addr_lo,
    input  logic               addr_top,
    input  logic               space_sel,
    input  logic               mux_ctl,
    output logic [FULL_AW-1:0] addr_full
);
    logic top_bit;
    always_comb begin
        top_bit   = mux_ctl ? space_sel : addr_top;
        addr_full = {top_bit, addr_lo};
    end
endmodule

// File: rtl/dsr_store.sv
module dsr_store #(
    parameter int AW = 11,
    parameter int DW = 24,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_word
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rd_word = mem[addr];
endmodule

// File: rtl/dual_en_sram.sv
module dual_en_sram
    import dual_en_sram_pkg::*;
#(
    parameter int LOW_AW = 10,
    parameter int DATA_W = 24,
    localparam int FULL_AW = LOW_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_lo_n,
    input  logic              ce_hi,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [LOW_AW-1:0] addr_lo,
    input  logic              addr_top,
    input  logic              space_sel,
    input  logic              mux_ctl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);
    logic               sel, wr, rd_req;
    logic [FULL_AW-1:0] addr_full;
    logic [DATA_W-1:0]  rd_word;
    acc_state_t         state_q, state_d;

    dsr_select_decode u_decode (
        .ce_lo_n (ce_lo_n),
        .ce_hi   (ce_hi),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .sel     (sel),
        .wr      (wr),
        .rd_req  (rd_req)
    );

    dsr_addr_mux #(.LOW_AW(LOW_AW)) u_mux (
        .addr_lo   (addr_lo),
        .addr_top  (addr_top),
        .space_sel (space_sel),
        .mux_ctl   (mux_ctl),
        .addr_full (addr_full)
    );

    dsr_store #(.AW(FULL_AW), .DW(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr),
        .addr    (addr_full),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STANDBY: begin
                if (!sel)        state_d = ST_STANDBY;
                else if (wr)     state_d = ST_LOCK;
                else if (rd_req) state_d = ST_READ;
                else             state_d = ST_QUIET;
            end
            ST_QUIET, ST_READ, ST_WRITE: begin
                if (!sel)        state_d = ST_STANDBY;
                else if (wr)     state_d = ST_WRITE;
                else if (rd_req) state_d = ST_READ;
                else             state_d = ST_QUIET;
            end
            ST_LOCK: begin
                if (!sel) state_d = ST_STANDBY;
                else      state_d = ST_LOCK;
            end
            default: state_d = ST_STANDBY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STANDBY;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_drive <= 1'b0;
            rdata       <= '0;
        end else begin
            rdata_drive <= (state_d == ST_READ);
            rdata       <= (state_d == ST_READ) ? rd_word : '0;
        end
    end

    assert_deselect_undriven_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !rdata_drive);

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && state_q != ST_LOCK) |=> rdata_drive);

    assert_oe_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && !rd_req) |=> !rdata_drive);

    assert_write_undriven_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !rdata_drive);

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && sel) |=> (!rdata_drive && state_q == ST_LOCK));
endmodule

// File: tb/dual_en_sram_bench.sv
module dual_en_sram_bench;
    localparam int LAW = 10;
    localparam int DW  = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_lo_n = 1'b1, ce_hi = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic [LAW-1:0] addr_lo = '0;
    logic          addr_top = 1'b0, space_sel = 1'b0, mux_ctl = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drive;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_en_sram u_dual_en_sram (
        .clk (clk), .rst_n (rst_n),
        .ce_lo_n (ce_lo_n), .ce_hi (ce_hi), .oe_n (oe_n), .we_n (we_n),
        .addr_lo (addr_lo), .addr_top (addr_top), .space_sel (space_sel),
        .mux_ctl (mux_ctl), .wdata (wdata),
        .rdata (rdata), .rdata_drive (rdata_drive)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: set inputs, cross the rising edge, return at the falling edge
    task automatic step(input logic lo_n, input logic hi, input logic oe, input logic we,
                        input logic [LAW-1:0] a, input logic t, input logic s,
                        input logic m, input logic [DW-1:0] d);
        ce_lo_n = lo_n; ce_hi = hi; oe_n = oe; we_n = we;
        addr_lo = a; addr_top = t; space_sel = s; mux_ctl = m; wdata = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b1, 1'b0, 1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic wr_word(input logic [LAW-1:0] a, input logic t, input logic s,
                           input logic m, input logic [DW-1:0] d, input logic oe);
        step(1'b0, 1'b1, oe, 1'b0, a, t, s, m, d);
        idle();
    endtask

    task automatic rd_check(input string tag, input logic [LAW-1:0] a, input logic t,
                            input logic s, input logic m, input logic [DW-1:0] exp);
        idle();
        step(1'b0, 1'b1, 1'b0, 1'b1, a, t, s, m, '0);
        check({tag, " drive"}, {31'd0, rdata_drive}, 32'd1);
        check({tag, " data"}, {8'd0, rdata}, {8'd0, exp});
    endtask

    task automatic t_reset();
        check("R8 drive after reset", {31'd0, rdata_drive}, 32'd0);
        check("R8 data after reset", {8'd0, rdata}, 32'd0);
    endtask

    task automatic t_mux_split();
        wr_word(10'd5, 1'b0, 1'b1, 1'b0, 24'hA1A1A1, 1'b1);
        wr_word(10'd5, 1'b1, 1'b0, 1'b0, 24'hB2B2B2, 1'b1);
        rd_check("R9 low word via addr_top", 10'd5, 1'b0, 1'b1, 1'b0, 24'hA1A1A1);
        rd_check("R9 high word via addr_top", 10'd5, 1'b1, 1'b0, 1'b0, 24'hB2B2B2);
        rd_check("R1 space_sel=0 picks low", 10'd5, 1'b1, 1'b0, 1'b1, 24'hA1A1A1);
        rd_check("R1 space_sel=1 picks high", 10'd5, 1'b0, 1'b1, 1'b1, 24'hB2B2B2);
    endtask

    task automatic t_deselect();
        step(1'b1, 1'b1, 1'b0, 1'b0, 10'd5, 1'b0, 1'b0, 1'b0, 24'h111111);
        check("R2 ce_lo_n high undriven", {31'd0, rdata_drive}, 32'd0);
        check("R7 zero data when undriven", {8'd0, rdata}, 32'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 10'd5, 1'b0, 1'b0, 1'b0, 24'h222222);
        check("R2 ce_hi low undriven", {31'd0, rdata_drive}, 32'd0);
        rd_check("R2 no write while deselected", 10'd5, 1'b0, 1'b0, 1'b0, 24'hA1A1A1);
    endtask

    task automatic t_oe_off();
        rd_check("R3 read before oe off", 10'd5, 1'b1, 1'b0, 1'b0, 24'hB2B2B2);
        step(1'b0, 1'b1, 1'b1, 1'b1, 10'd5, 1'b1, 1'b0, 1'b0, 24'h333333);
        check("R4 oe high undriven", {31'd0, rdata_drive}, 32'd0);
        check("R7 oe high zero data", {8'd0, rdata}, 32'd0);
        rd_check("R4 no write with oe high", 10'd5, 1'b1, 1'b0, 1'b0, 24'hB2B2B2);
    endtask

    task automatic t_write_oe_low();
        idle();
        step(1'b0, 1'b1, 1'b1, 1'b1, 10'd7, 1'b0, 1'b0, 1'b0, '0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 10'd7, 1'b0, 1'b0, 1'b0, 24'hC3C3C3);
        check("R5 write with oe low undriven", {31'd0, rdata_drive}, 32'd0);
        rd_check("R5 write with oe low stored", 10'd7, 1'b0, 1'b0, 1'b0, 24'hC3C3C3);
    endtask

    task automatic t_lock();
        idle();
        step(1'b0, 1'b1, 1'b0, 1'b0, 10'd9, 1'b1, 1'b0, 1'b0, 24'hD4D4D4);
        check("R6 select with we low undriven", {31'd0, rdata_drive}, 32'd0);
        step(1'b0, 1'b1, 1'b0, 1'b1, 10'd9, 1'b1, 1'b0, 1'b0, '0);
        check("R6 read after lock undriven", {31'd0, rdata_drive}, 32'd0);
        check("R6 read after lock zero data", {8'd0, rdata}, 32'd0);
        rd_check("R6 locked write stored", 10'd9, 1'b1, 1'b0, 1'b0, 24'hD4D4D4);
    endtask

    task automatic t_back_to_back();
        rd_check("R10 read before overwrite", 10'd7, 1'b0, 1'b0, 1'b0, 24'hC3C3C3);
        step(1'b0, 1'b1, 1'b0, 1'b0, 10'd7, 1'b0, 1'b0, 1'b0, 24'hE5E5E5);
        check("R5 drive drops on write edge", {31'd0, rdata_drive}, 32'd0);
        step(1'b0, 1'b1, 1'b0, 1'b1, 10'd7, 1'b0, 1'b0, 1'b0, '0);
        check("R10 next-cycle drive", {31'd0, rdata_drive}, 32'd1);
        check("R10 next-cycle new word", {8'd0, rdata}, 32'h00E5E5E5);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mux_split();
        t_deselect();
        t_oe_off();
        t_write_oe_low();
        t_lock();
        t_back_to_back();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule